// File: doc/BRIEF.md
# Running top-K merger

This block keeps a running list of the K smallest keys that have passed through it. Its input is a stream of runs. Each run holds exactly K keys in ascending order, and the keys arrive one per valid cycle. Idle cycles may fall anywhere, including inside a run. For every key it accepts, the block emits one key one cycle later. The K keys emitted during a run are, in ascending order, the K smallest unsigned keys received since reset. The K-th key of each run carries an end-of-run marker.

Two K-deep result stores take turns. One of them holds the current survivors. During a run, the block repeatedly compares the head of that store with the smallest pending key of the run. The smallest pending key is either the head of a K/2-deep buffer or, when the buffer is empty, the key arriving in that cycle. The winner is written into the other store and emitted. When the winner is a new key, the survivor store gives up its tail key, which is its largest, instead of its head. Once the buffer is full, any further key of the run cannot qualify and is dropped. At the end of a run the buffer is cleared and the two stores swap roles.

Top module: `topk_merger`

## Requirements
- R1: While reset is held, and after it is released, out_valid and out_last are low until a key is accepted.
- R2: Every cycle with in_valid high produces exactly one output cycle with out_valid high on the next cycle. A cycle with in_valid low produces no output on the next cycle.
- R3: During the first run after reset, the output repeats each input key unchanged, one cycle later.
- R4: During every later run, the K outputs are the K smallest keys received since reset, in ascending unsigned order. Equal keys are allowed, and duplicates are kept.
- R5: out_last is high on the output of the K-th key of each run and low on every other output.
- R6: Idle cycles between the keys of a run do not change the keys that the run emits.
- R7: A run whose keys are all larger than the current survivors leaves the emitted list equal to the previous run's list.
- R8: The pending-key buffer never holds more than K/2 keys. Keys that arrive while it is full are dropped, and the result is still that of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A key is presented this cycle |
| in_key | input | KW | Input key; runs of K keys in ascending order |
| out_valid | output | 1 | out_key is valid |
| out_key | output | KW | Emitted key |
| out_last | output | 1 | This is the K-th emitted key of the run |

## Verification
The bench builds the block with K = 8 and 12-bit keys. This makes the pending buffer four deep, so it fills after only a few wins by the survivor store. Eight-key runs are short enough to steer by hand into the cases that matter: runs entirely above or entirely below the survivors, runs that interleave with the survivors one for one, runs that exactly duplicate the survivors, and runs with idle gaps. Several random runs follow, checked against a sorted reference list kept in the bench.

// File: rtl/topk_merger.sv
module topk_merger #(
  parameter int KW = 16,
  parameter int K  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [KW-1:0] in_key,
  output logic          out_valid,
  output logic [KW-1:0] out_key,
  output logic          out_last
);
  localparam int HALF = K / 2;
  localparam int AW   = $clog2(K);
  localparam int CAW  = $clog2(HALF);
  localparam logic [AW-1:0] LASTI = AW'(K - 1);
  localparam logic [AW:0]   KCNT  = (AW + 1)'(K);
  localparam logic [CAW:0]  CFULL = (CAW + 1)'(HALF);

  logic [KW-1:0] rmem [2][K];
  logic [AW-1:0] rhd [2];
  logic [AW-1:0] rtl [2];
  logic [AW:0]   rcnt [2];

  logic [KW-1:0] cmem [HALF];
  logic [CAW-1:0] chd, ctl;
  logic [CAW:0]   ccnt;

  logic          sel, first;
  logic [AW-1:0] idx;

  wire          run_end = in_valid && (idx == LASTI);
  wire          c_has   = (ccnt != '0);
  wire [KW-1:0] c_key   = c_has ? cmem[chd] : in_key;
  wire [KW-1:0] r_key   = rmem[sel][rhd[sel]];
  wire          take_c  = c_key < r_key;
  wire [KW-1:0] win     = first ? in_key : (take_c ? c_key : r_key);
  wire          dst     = first ? sel : !sel;
  wire          merging = in_valid && !first;
  wire          c_pop   = merging && take_c && c_has;
  wire          c_push  = merging && !(take_c && !c_has) && (ccnt != CFULL) && !run_end;
  wire          c_clear = merging && run_end;

  always_ff @(posedge clk) begin
    if (in_valid) rmem[dst][rtl[dst]] <= win;
    if (c_push) cmem[ctl] <= in_key;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < 2; f++) begin
        rhd[f]  <= '0;
        rtl[f]  <= '0;
        rcnt[f] <= '0;
      end
    end else if (in_valid) begin
      for (int f = 0; f < 2; f++) begin
        if (dst == 1'(f)) begin
          rtl[f]  <= rtl[f] + 1'b1;
          rcnt[f] <= rcnt[f] + 1'b1;
        end else if (!first && sel == 1'(f)) begin
          if (take_c) rtl[f] <= rtl[f] - 1'b1;
          else        rhd[f] <= rhd[f] + 1'b1;
          rcnt[f] <= rcnt[f] - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chd  <= '0;
      ctl  <= '0;
      ccnt <= '0;
    end else if (c_clear) begin
      chd  <= '0;
      ctl  <= '0;
      ccnt <= '0;
    end else begin
      if (c_push) ctl <= ctl + 1'b1;
      if (c_pop)  chd <= chd + 1'b1;
      ccnt <= ccnt + (CAW + 1)'(c_push) - (CAW + 1)'(c_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      first     <= 1'b1;
      sel       <= 1'b0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_key   <= '0;
    end else begin
      out_valid <= in_valid;
      out_last  <= run_end;
      if (in_valid) begin
        out_key <= win;
        idx     <= idx + 1'b1;
      end
      if (run_end) begin
        if (first) first <= 1'b0;
        else       sel   <= !sel;
      end
    end
  end

  logic          chk_live;
  logic [KW-1:0] chk_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_live <= 1'b0;
      chk_prev <= '0;
    end else if (out_valid) begin
      chk_live <= !out_last;
      chk_prev <= out_key;
    end
  end

  a_r2_output_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r5_last_on_kth: assert property (@(posedge clk) disable iff (!rst_n)
    run_end |=> out_last);
  a_r5_last_only_kth: assert property (@(posedge clk) disable iff (!rst_n)
    !run_end |=> !out_last);
  a_r8_buffer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ccnt <= CFULL);
  a_r8_cleared_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> ccnt == '0);
  a_r4_survivors_full: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> rcnt[sel] == KCNT);
  a_r4_source_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    merging |-> rcnt[sel] != '0);
  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && chk_live) |-> out_key >= chk_prev);
endmodule

// File: tb/topk_merger_test.sv
module topk_merger_test;
  localparam int K = 8;
  localparam int KW = 12;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [KW-1:0] in_key;
  logic          out_valid;
  logic [KW-1:0] out_key;
  logic          out_last;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [KW-1:0] top[$];
  logic [KW-1:0] exp_key[$];
  bit            exp_last[$];
  string         exp_tag[$];

  topk_merger #(.KW(KW), .K(K)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
    .out_valid(out_valid), .out_key(out_key), .out_last(out_last)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic send_run(input logic [KW-1:0] keys[$], input int gap, input string tag);
    logic [KW-1:0] all[$];
    logic [KW-1:0] run[$];
    run = keys;
    run.sort();
    all = top;
    foreach (run[i]) all.push_back(run[i]);
    all.sort();
    top.delete();
    for (int i = 0; i < K; i++) begin
      top.push_back(all[i]);
      exp_key.push_back(all[i]);
      exp_last.push_back(i == K - 1);
      exp_tag.push_back(tag);
    end
    for (int i = 0; i < K; i++) begin
      if (gap > 0 && (i % 2) == 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_valid = 1'b0;
        end
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_key   = run[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic void rand_run(output logic [KW-1:0] q[$], input int lo, input int hi);
    q.delete();
    for (int i = 0; i < K; i++) q.push_back(KW'($urandom_range(hi, lo)));
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_key.size() == 0) begin
        check(1'b0, "R2", "unexpected output", int'(out_key), -1);
      end else begin
        logic [KW-1:0] k;
        bit l;
        string t;
        k = exp_key.pop_front();
        l = exp_last.pop_front();
        t = exp_tag.pop_front();
        check(out_key == k, t, "key", int'(out_key), int'(k));
        check(out_last == l, "R5", "end-of-run marker", int'(out_last), int'(l));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [KW-1:0] q[$];
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_key = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(out_last == 1'b0, "R1", "out_last in reset", int'(out_last), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    rand_run(q, 200, 2000);   send_run(q, 0, "R3");
    rand_run(q, 0, 4095);     send_run(q, 0, "R4");
    rand_run(q, 3000, 4095);  send_run(q, 0, "R7");
    rand_run(q, 0, 60);       send_run(q, 0, "R4");
    q.delete();
    foreach (top[i]) q.push_back(top[i] + 1'b1);
    send_run(q, 0, "R8");
    q.delete();
    foreach (top[i]) q.push_back(top[i]);
    send_run(q, 0, "R4");
    rand_run(q, 0, 200);      send_run(q, 2, "R6");
    rand_run(q, 3000, 4095);  send_run(q, 1, "R7");
    for (int r = 0; r < 6; r++) begin
      rand_run(q, 0, 150);
      send_run(q, r % 3, "R4");
    end

    repeat (4) @(negedge clk);
    check(exp_key.size() == 0, "R2", "outputs still owed", exp_key.size(), 0);
    check(out_valid == 1'b0, "R2", "out_valid when idle", int'(out_valid), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule